// File: doc/BRIEF.md
# Power-Domain Register Access Proxy

This block lets a host reach registers that sit behind power-gated domains without first waking the domain through software. The host sees a pair of 32-bit registers in its own register space: a data word and a control word. Setting the launch bit in the control word starts one indirect access. The engine then raises a wake request for the selected domain (or for every domain), waits for the acknowledge, and performs one 32-bit read or write on an internal register bus. After that it drops the wake request and clears the launch bit.

The host polls the launch bit. A write needs its value placed in the data word before launch. After a read, the data word holds the fetched value. Domain power sequencing is a plain request/acknowledge handshake per domain. If the acknowledge does not arrive within a cycle limit set on an input, the access is abandoned and a sticky error flag is raised.

Top module: `pgate_reg_proxy`

## Requirements
- R1: After reset the data word and the control word read as 0, no wake request is raised, `ib_valid` is 0 and `wake_err` is 0.
- R2: The data word is at host byte address 0xF00 and the control word at 0xF04. In the control word, bit 31 is the launch/busy bit, bits 30:28 select the domain, bit 24 is the operation (0 = write, 1 = read) and bits 23:0 hold the target byte offset. Bits 27:25 always read as 0. Any other host address reads as 0.
- R3: Writing the control word with bit 31 set while idle starts an access. Bit 31 reads as 1 from the next cycle until the access ends, and then it reads as 0. Writing with bit 31 clear only stores the fields and starts nothing.
- R4: `pwr_req` bit 0, 1 or 2 is raised alone for domain code 0, 1 or 2. Domain codes 3 to 7 raise all three bits. The engine waits until every raised bit is acknowledged.
- R5: A write launch drives exactly one internal bus beat with `ib_write`=1, `ib_addr` equal to the offset field and `ib_wdata` equal to the data word. The bus signals are held until `ib_ready`.
- R6: A read launch drives exactly one beat with `ib_write`=0. The returned `ib_rdata` is loaded into the data word by the time bit 31 reads 0.
- R7: While an access is in progress, host writes to the control word and to the data word are ignored.
- R8: If the acknowledges are not all present within `wake_limit` cycles of the wake phase (a limit of 0 acts as 1), the engine makes no bus beat, clears bit 31 and sets `wake_err`. On a read it also loads 0xFFFFFFFF into the data word.
- R9: `wake_err` stays set until the next launch, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | 12 | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, combinational from `hst_addr` |
| wake_limit | input | 16 | Wake-acknowledge timeout in cycles |
| pwr_req | output | 3 | Per-domain wake request |
| pwr_ack | input | 3 | Per-domain wake acknowledge |
| ib_valid | output | 1 | Internal bus request |
| ib_write | output | 1 | Internal bus direction, 1 = write |
| ib_addr | output | 24 | Internal bus byte offset |
| ib_wdata | output | 32 | Internal bus write data |
| ib_ready | input | 1 | Internal bus completion |
| ib_rdata | input | 32 | Internal bus read data |
| wake_err | output | 1 | Sticky wake-timeout flag |

## Verification
The bench stalls the internal bus mid-access and then writes new values into both host registers. A proxy that let those writes through would store the second data value at the second offset instead of the original pair. The bench withholds one acknowledge on an all-domain access. A design that waited for only some acknowledges would make a bus beat, and one without a timeout would never clear the busy bit. A read abort must leave all-ones in the data word, not stale data. A delayed acknowledge that arrives inside the limit must still complete, which catches a timer that counts across accesses or fires early.

// File: rtl/rp_pkg.sv
package rp_pkg;

    localparam int WORD_W   = 32;
    localparam int OFF_W    = 24;
    localparam int DOM_W    = 3;

    // host register map (byte addresses)
    localparam int DATA_ADR = 32'hF00;
    localparam int CTRL_ADR = 32'hF04;

    // control word layout
    localparam int GO_POS   = 31;
    localparam int DOM_LSB  = 28;
    localparam int OP_POS   = 24;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAKE = 2'd1,
        ST_XFER = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic [DOM_W-1:0] dom;
        logic             op_rd;
        logic [OFF_W-1:0] off;
    } ctl_t;

endpackage

// File: rtl/rp_host_regs.sv
module rp_host_regs
    import rp_pkg::*;
#(
    parameter int HADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_wr,
    input  logic [HADDR_W-1:0] hst_addr,
    input  logic [WORD_W-1:0]  hst_wdata,
    output logic [WORD_W-1:0]  hst_rdata,
    input  logic               busy,
    input  logic               ld_en,
    input  logic [WORD_W-1:0]  ld_val,
    output ctl_t               ctl_q_o,
    output logic [WORD_W-1:0]  data_q_o,
    output logic               launch
);

    localparam logic [HADDR_W-1:0] DATA_A = HADDR_W'(DATA_ADR);
    localparam logic [HADDR_W-1:0] CTRL_A = HADDR_W'(CTRL_ADR);

    typedef struct packed {
        logic [WORD_W-1:0] data;
        ctl_t              ctl;
    } regs_t;

    regs_t r_q, r_d;
    logic  sel_data, sel_ctrl;

    always_comb begin
        r_d      = r_q;
        launch   = 1'b0;
        sel_data = (hst_addr == DATA_A);
        sel_ctrl = (hst_addr == CTRL_A);

        if (hst_wr && sel_data && !busy) begin
            r_d.data = hst_wdata;
        end
        if (hst_wr && sel_ctrl && !busy) begin
            r_d.ctl.dom   = hst_wdata[DOM_LSB +: DOM_W];
            r_d.ctl.op_rd = hst_wdata[OP_POS];
            r_d.ctl.off   = hst_wdata[OFF_W-1:0];
            launch        = hst_wdata[GO_POS];
        end
        if (ld_en) begin
            r_d.data = ld_val;
        end

        if (sel_data) begin
            hst_rdata = r_q.data;
        end else if (sel_ctrl) begin
            hst_rdata = {busy, r_q.ctl.dom, 3'b000, r_q.ctl.op_rd, r_q.ctl.off};
        end else begin
            hst_rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl_q_o  = r_q.ctl;
    assign data_q_o = r_q.data;

    AST_CTL_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(r_q.ctl)); // R7

    AST_DATA_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hst_wr && sel_data && !ld_en) |=> $stable(r_q.data)); // R7

endmodule

// File: rtl/rp_wake_timer.sv
module rp_wake_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    logic [TMO_W-1:0] cnt_q, cnt_d;
    logic [TMO_W-1:0] lim_eff;

    always_comb begin
        lim_eff = (limit == '0) ? TMO_W'(1) : limit;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == '1) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
        expired = run && (({1'b0, cnt_q} + (TMO_W+1)'(1)) >= {1'b0, lim_eff});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/rp_domain_req.sv
module rp_domain_req
    import rp_pkg::*;
#(
    parameter int N_DOM = 3
) (
    input  logic             active,
    input  logic [DOM_W-1:0] dom,
    input  logic [N_DOM-1:0] ack,
    output logic [N_DOM-1:0] req,
    output logic             all_ack
);

    for (genvar i = 0; i < N_DOM; i++) begin : g_dom
        assign req[i] = active && ((dom == DOM_W'(i)) || (dom >= DOM_W'(N_DOM)));
    end

    assign all_ack = active && ((ack & req) == req);

endmodule

// File: rtl/rp_seq.sv
module rp_seq
    import rp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  ctl_t              ctl,
    input  logic [WORD_W-1:0] data_q,
    input  logic              all_ack,
    input  logic              expired,
    input  logic              ib_ready,
    input  logic [WORD_W-1:0] ib_rdata,
    output logic              busy,
    output logic              tmr_run,
    output logic              ib_valid,
    output logic              ib_write,
    output logic [OFF_W-1:0]  ib_addr,
    output logic [WORD_W-1:0] ib_wdata,
    output logic              ld_en,
    output logic [WORD_W-1:0] ld_val,
    output logic              err
);

    typedef struct packed {
        seq_st_e st;
        logic    err;
    } seq_t;

    seq_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        ld_en    = 1'b0;
        ld_val   = ib_rdata;
        ib_valid = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (launch) begin
                    s_d.st  = ST_WAKE;
                    s_d.err = 1'b0;
                end
            end
            ST_WAKE: begin
                if (all_ack) begin
                    s_d.st = ST_XFER;
                end else if (expired) begin
                    s_d.st  = ST_IDLE;
                    s_d.err = 1'b1;
                    ld_en   = ctl.op_rd;
                    ld_val  = '1;
                end
            end
            ST_XFER: begin
                ib_valid = 1'b1;
                if (ib_ready) begin
                    s_d.st = ST_IDLE;
                    ld_en  = ctl.op_rd;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.st != ST_IDLE);
    assign tmr_run  = (s_q.st == ST_WAKE);
    assign ib_write = !ctl.op_rd;
    assign ib_addr  = ctl.off;
    assign ib_wdata = data_q;
    assign err      = s_q.err;

    AST_ERR_FROM_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.err) |-> $past(s_q.st == ST_WAKE)); // R8

    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_valid && !ib_ready) |=> (ib_valid && $stable(ib_addr) && $stable(ib_write) && $stable(ib_wdata))); // R5

    AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_valid && ib_ready) |=> !ib_valid); // R6

    AST_ERR_CLEAR_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !busy) |=> !s_q.err); // R9

endmodule

// File: rtl/pgate_reg_proxy.sv
module pgate_reg_proxy
    import rp_pkg::*;
#(
    parameter int HADDR_W = 12,
    parameter int TMO_W   = 16,
    parameter int N_DOM   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_wr,
    input  logic [HADDR_W-1:0] hst_addr,
    input  logic [31:0]        hst_wdata,
    output logic [31:0]        hst_rdata,
    input  logic [TMO_W-1:0]   wake_limit,
    output logic [N_DOM-1:0]   pwr_req,
    input  logic [N_DOM-1:0]   pwr_ack,
    output logic               ib_valid,
    output logic               ib_write,
    output logic [23:0]        ib_addr,
    output logic [31:0]        ib_wdata,
    input  logic               ib_ready,
    input  logic [31:0]        ib_rdata,
    output logic               wake_err
);

    ctl_t              ctl_q;
    logic [WORD_W-1:0] data_q;
    logic              launch, busy, tmr_run, expired, all_ack, ld_en;
    logic [WORD_W-1:0] ld_val;

    rp_host_regs #(.HADDR_W(HADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .hst_wr    (hst_wr),
        .hst_addr  (hst_addr),
        .hst_wdata (hst_wdata),
        .hst_rdata (hst_rdata),
        .busy      (busy),
        .ld_en     (ld_en),
        .ld_val    (ld_val),
        .ctl_q_o   (ctl_q),
        .data_q_o  (data_q),
        .launch    (launch)
    );

    rp_domain_req #(.N_DOM(N_DOM)) u_dom (
        .active  (busy),
        .dom     (ctl_q.dom),
        .ack     (pwr_ack),
        .req     (pwr_req),
        .all_ack (all_ack)
    );

    rp_wake_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .limit   (wake_limit),
        .expired (expired)
    );

    rp_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .ctl      (ctl_q),
        .data_q   (data_q),
        .all_ack  (all_ack),
        .expired  (expired),
        .ib_ready (ib_ready),
        .ib_rdata (ib_rdata),
        .busy     (busy),
        .tmr_run  (tmr_run),
        .ib_valid (ib_valid),
        .ib_write (ib_write),
        .ib_addr  (ib_addr),
        .ib_wdata (ib_wdata),
        .ld_en    (ld_en),
        .ld_val   (ld_val),
        .err      (wake_err)
    );

    AST_BEAT_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ib_valid |-> (pwr_req != '0)); // R4

    AST_REQ_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pwr_req)); // R4

endmodule

// File: tb/pgate_reg_proxy_tb.sv
module pgate_reg_proxy_tb;

    localparam logic [11:0] A_DATA = 12'hF00;
    localparam logic [11:0] A_CTRL = 12'hF04;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_wr = 1'b0;
    logic [11:0] hst_addr = 12'h000;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic [15:0] wake_limit = 16'd8;
    logic [2:0]  pwr_req, pwr_ack;
    logic        ib_valid, ib_write, ib_ready;
    logic [23:0] ib_addr;
    logic [31:0] ib_wdata, ib_rdata;
    logic        wake_err;

    logic [2:0]  ack_en = 3'b111;
    logic        slv_en = 1'b1;
    logic [2:0]  ack_q;
    logic [31:0] mem [16];
    int          wr_cnt;
    logic [2:0]  req_seen;
    logic        seen_clr = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    pgate_reg_proxy u_dut (
        .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .wake_limit(wake_limit),
        .pwr_req(pwr_req), .pwr_ack(pwr_ack), .ib_valid(ib_valid),
        .ib_write(ib_write), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
        .ib_ready(ib_ready), .ib_rdata(ib_rdata), .wake_err(wake_err)
    );

    // domain power model: acknowledge one cycle after request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_q <= '0;
        else        ack_q <= pwr_req & ack_en;
    end
    assign pwr_ack = ack_q;

    // internal register target
    assign ib_ready = ib_valid & slv_en;
    assign ib_rdata = mem[ib_addr[5:2]];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt <= 0;
        end else if (ib_valid && ib_ready && ib_write) begin
            mem[ib_addr[5:2]] <= ib_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    always_ff @(posedge clk) begin
        if (seen_clr) req_seen <= '0;
        else          req_seen <= req_seen | pwr_req;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic hr(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        hst_addr = a;
        #1 v = hst_rdata;
    endtask

    task automatic clr_seen();
        @(negedge clk); seen_clr = 1'b1;
        @(negedge clk); seen_clr = 1'b0;
    endtask

    task automatic go(input logic [2:0] dom, input logic rd, input logic [23:0] off);
        hw(A_CTRL, {1'b1, dom, 3'b000, rd, off});
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] v;
        for (int i = 0; i < 200; i++) begin
            hr(A_CTRL, v);
            if (!v[31]) return;
        end
        chk({tag, " busy never cleared"}, 32'd1, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        hr(A_DATA, v); chk("R1 data after reset", v, 32'h0);
        hr(A_CTRL, v); chk("R1 ctrl after reset", v, 32'h0);
        chk("R1 pwr_req after reset", {29'd0, pwr_req}, 32'h0);
        chk("R1 ib_valid/err after reset", {30'd0, ib_valid, wake_err}, 32'h0);
        hr(12'h100, v); chk("R2 unmapped reads zero", v, 32'h0);
    endtask

    task automatic t_write_render();
        logic [31:0] v;
        int c0 = wr_cnt;
        hw(A_DATA, 32'hA5A5_1234);
        clr_seen();
        go(3'd1, 1'b0, 24'h000010);
        hr(A_CTRL, v); chk("R3 busy after launch", {31'd0, v[31]}, 32'd1);
        wait_idle("R3");
        hr(A_CTRL, v); chk("R3 busy cleared, fields kept", v, 32'h1000_0010);
        chk("R5 write stored at offset", mem[4], 32'hA5A5_1234);
        chk("R5 one write beat", wr_cnt - c0, 32'd1);
        chk("R4 render request only", {29'd0, req_seen}, 32'h2);
    endtask

    task automatic t_read_media();
        logic [31:0] v;
        hw(A_DATA, 32'h0);
        clr_seen();
        go(3'd2, 1'b1, 24'h000010);
        wait_idle("R6");
        hr(A_DATA, v); chk("R6 read data loaded", v, 32'hA5A5_1234);
        chk("R4 media request only", {29'd0, req_seen}, 32'h4);
    endtask

    task automatic t_blitter_all();
        int c0;
        hw(A_DATA, 32'h0BAD_F00D);
        clr_seen();
        go(3'd0, 1'b0, 24'h000008);
        wait_idle("R4 blit");
        chk("R4 blitter request only", {29'd0, req_seen}, 32'h1);
        chk("R5 blitter write", mem[2], 32'h0BAD_F00D);
        clr_seen();
        c0 = wr_cnt;
        hw(A_DATA, 32'hCAFE_0003);
        go(3'd3, 1'b0, 24'h000020);
        wait_idle("R4 all");
        chk("R4 all domains requested", {29'd0, req_seen}, 32'h7);
        chk("R5 all-domain write", mem[8], 32'hCAFE_0003);
        clr_seen();
        go(3'd6, 1'b1, 24'h000020);
        wait_idle("R4 code6");
        chk("R4 code 6 acts as all", {29'd0, req_seen}, 32'h7);
        chk("R6 code 6 read", wr_cnt - c0, 32'd1);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        int c0 = wr_cnt;
        hw(A_CTRL, 32'h7FFF_FFFF);
        hr(A_CTRL, v); chk("R2 reserved bits read zero", v, 32'h71FF_FFFF);
        repeat (4) @(negedge clk);
        chk("R3 no launch without bit31", {29'd0, pwr_req}, 32'h0);
        chk("R3 no beat without bit31", wr_cnt - c0, 32'd0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        slv_en = 1'b0;
        hw(A_DATA, 32'h1111_1111);
        go(3'd0, 1'b0, 24'h000030);
        repeat (6) @(negedge clk);
        hw(A_DATA, 32'h2222_2222);
        hw(A_CTRL, {1'b1, 3'd2, 4'b0001, 24'h000034});
        hr(A_CTRL, v); chk("R7 ctrl unchanged while busy", v, 32'h8000_0030);
        hr(A_DATA, v); chk("R7 data unchanged while busy", v, 32'h1111_1111);
        slv_en = 1'b1;
        wait_idle("R7");
        chk("R7 original pair written", mem[12], 32'h1111_1111);
        chk("R7 ignored offset untouched", mem[13] === 32'h2222_2222 ? 32'd1 : 32'd0, 32'd0);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        int c0 = wr_cnt;
        ack_en = 3'b011;
        hw(A_DATA, 32'h5555_0005);
        go(3'd3, 1'b0, 24'h000024);
        wait_idle("R8 write");
        chk("R8 error after write abort", {31'd0, wake_err}, 32'd1);
        chk("R8 no beat on abort", wr_cnt - c0, 32'd0);
        hr(A_DATA, v); chk("R8 write abort keeps data", v, 32'h5555_0005);
        go(3'd2, 1'b1, 24'h000010);
        wait_idle("R8 read");
        hr(A_DATA, v); chk("R8 read abort loads ones", v, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        chk("R9 error sticky", {31'd0, wake_err}, 32'd1);
        ack_en = 3'b111;
        go(3'd1, 1'b1, 24'h000010);
        wait_idle("R9");
        chk("R9 launch clears error", {31'd0, wake_err}, 32'd0);
        hr(A_DATA, v); chk("R6 read after recovery", v, 32'hA5A5_1234);
    endtask

    task automatic t_late_ack();
        logic [31:0] v;
        ack_en = 3'b000;
        go(3'd2, 1'b1, 24'h000008);
        repeat (4) @(negedge clk);
        ack_en = 3'b111;
        wait_idle("R8 late");
        chk("R8 ack inside limit no error", {31'd0, wake_err}, 32'd0);
        hr(A_DATA, v); chk("R8 ack inside limit reads", v, 32'h0BAD_F00D);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_render();
        t_read_media();
        t_blitter_all();
        t_reserved();
        t_busy_ignore();
        t_abort();
        t_late_ack();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule